// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives an SDRAM command bus from reset until the memory is ready for ordinary traffic. It first holds clock enable and the data mask high and issues only no-operation commands for a settling window whose length in cycles is the clock frequency in MHz times the window length in microseconds. It then precharges every bank, issues a programmable number of auto-refresh commands (never fewer than two), and loads the mode register with a configured word. Each command is followed by enough no-operation cycles to cover its recovery time.

A parameter selects whether the refresh burst or the mode-register load comes first. When the last command's recovery has elapsed, the block raises `init_done`. The surrounding controller uses that flag to take over the command bus. A reset at any moment restarts the whole sequence from the settling window.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and for WAIT_CYC = max(1, CLK_MHZ*WAIT_US) cycles after it is released, the bus carries NOP. NOP means cs_n=0, ras_n=1, cas_n=1 and we_n=1. During this time dqm=1, ba=0, addr=0 and init_done=0.
- R2: In the cycle that directly follows the window, the block issues one precharge-all for one cycle. This is cs_n=0, ras_n=0, cas_n=1, we_n=0, with addr bit 10 set, every other addr bit 0 and ba=0.
- R3: Each command has a spacing of T cycles: after it come T-1 NOP cycles, and the next command appears T cycles after it. T is T_RP after a precharge, T_RC after a refresh and T_MRD after a mode load. Each T is raised to 2 if it is set lower.
- R4: The block issues exactly max(2, REFRESH_COUNT) auto-refresh commands. The encoding is cs_n=0, ras_n=0, cas_n=0, we_n=1, with addr=0 and ba=0.
- R5: The block issues exactly one mode-register load. The encoding is all four command lines at 0, with addr=MODE_WORD and ba=0.
- R6: With MRS_FIRST=0, the refresh commands follow the precharge and the mode load comes last. With MRS_FIRST=1, the mode load follows the precharge and the refreshes come last.
- R7: init_done rises T cycles after the final command, where T is that command's spacing. It then stays high until reset. While it is high, the bus carries NOP with dqm=0.
- R8: A reset asserted at any point returns the outputs to the R1 state. After release, the full sequence restarts from the beginning of the window.
- R9: cke is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed address |
| init_done | output | 1 | Sequence complete; bus may be handed over |

## Verification
The bench builds two instances side by side, and the two settings cover both orderings and both clamps.
- The first instance uses a 1 MHz clock with a 25 µs window, refresh-first order, three refreshes, and distinct spacings of 3, 4 and 2 cycles. With these values, a command that is early or late by one cycle lands on a different expected slot.
- The second instance uses a 2 MHz clock with a 9 µs window and mode-load-first order. It requests a single refresh and a precharge spacing of 1, so the raise to two refreshes and the raise to a spacing of 2 are both visible.

Because the windows are short, random reset points reach every phase, including the cycle just after completion.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ       = 100,
  parameter int WAIT_US       = 200,
  parameter int T_RP          = 3,
  parameter int T_RC          = 9,
  parameter int T_MRD         = 2,
  parameter int REFRESH_COUNT = 2,
  parameter bit MRS_FIRST     = 1'b0,
  parameter int ADDR_W        = 11,
  parameter int BA_W          = 1,
  parameter logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(11'h030)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_dqm,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  localparam int WAIT_RAW = CLK_MHZ * WAIT_US;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int RP   = (T_RP  < 2) ? 2 : T_RP;
  localparam int RC   = (T_RC  < 2) ? 2 : T_RC;
  localparam int MRD  = (T_MRD < 2) ? 2 : T_MRD;
  localparam int NREF = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
  localparam int GMAX = (RP > RC) ? ((RP > MRD) ? RP : MRD) : ((RC > MRD) ? RC : MRD);
  localparam int CMAX = (WAIT_CYC > GMAX) ? WAIT_CYC : GMAX;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = $clog2(NREF + 1);

  typedef enum logic [2:0] {ST_WAIT, ST_PRE, ST_REF, ST_MRS, ST_GAP, ST_DONE} st_t;

  st_t           state, last, nxt;
  logic [CW-1:0] cnt, gap;
  logic [RW-1:0] ref_cnt;

  always_comb begin
    nxt = ST_DONE;
    case (last)
      ST_PRE:  nxt = MRS_FIRST ? ST_MRS : ST_REF;
      ST_REF:  nxt = (ref_cnt < RW'(NREF)) ? ST_REF : (MRS_FIRST ? ST_DONE : ST_MRS);
      ST_MRS:  nxt = MRS_FIRST ? ST_REF : ST_DONE;
      default: nxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      last    <= ST_PRE;
      cnt     <= '0;
      gap     <= '0;
      ref_cnt <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (cnt == CW'(WAIT_CYC - 1)) begin
            state <= ST_PRE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PRE: begin
          last  <= ST_PRE;
          gap   <= CW'(RP - 2);
          cnt   <= '0;
          state <= ST_GAP;
        end
        ST_REF: begin
          last    <= ST_REF;
          ref_cnt <= ref_cnt + 1'b1;
          gap     <= CW'(RC - 2);
          cnt     <= '0;
          state   <= ST_GAP;
        end
        ST_MRS: begin
          last  <= ST_MRS;
          gap   <= CW'(MRD - 2);
          cnt   <= '0;
          state <= ST_GAP;
        end
        ST_GAP: begin
          if (cnt == gap) begin
            state <= nxt;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  logic [3:0] code;
  assign code = (state == ST_PRE) ? 4'b0010 :
                (state == ST_REF) ? 4'b0001 :
                (state == ST_MRS) ? 4'b0000 : 4'b0111;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = code;
  assign sd_cke    = 1'b1;
  assign sd_ba     = '0;
  assign sd_addr   = (state == ST_PRE) ? ADDR_W'(1 << 10) :
                     (state == ST_MRS) ? MODE_WORD : '0;
  assign init_done = (state == ST_DONE);
  assign sd_dqm    = ~init_done;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dqm,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  logic [3:0] c;
  logic [7:0] refs;
  logic       saw_pre;
  assign c = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refs    <= '0;
      saw_pre <= 1'b0;
    end else begin
      if (c == 4'b0001 && refs != 8'hff) refs <= refs + 1'b1;
      if (c == 4'b0010) saw_pre <= 1'b1;
    end
  end

  assert_cke_high_R9: assert property (@(posedge clk) disable iff (!rst_n) cke);
  assert_mask_until_done_R1: assert property (@(posedge clk) disable iff (!rst_n) !init_done |-> dqm);
  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n) (c == 4'b0010) |-> addr[10]);
  assert_pre_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0001 || c == 4'b0000) |-> saw_pre);
  assert_refresh_min_R4: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> refs >= 8'd2);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done);
  assert_done_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (c == 4'b0111 && !dqm));
  assert_selected_R1: assert property (@(posedge clk) disable iff (!rst_n) !cs_n);
  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c != 4'b0111) |=> (c == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
  .cas_n(sd_cas_n), .we_n(sd_we_n), .dqm(sd_dqm), .addr(sd_addr), .init_done(init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_dqm, a_done;
  logic [0:0]  a_ba;
  logic [10:0] a_addr;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_dqm, b_done;
  logic [0:0]  b_ba;
  logic [10:0] b_addr;

  sdram_init_seq #(.CLK_MHZ(1), .WAIT_US(25), .T_RP(3), .T_RC(4), .T_MRD(2),
    .REFRESH_COUNT(3), .MRS_FIRST(1'b0), .MODE_WORD(11'h037)) u0 (
    .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_dqm(a_dqm), .sd_ba(a_ba),
    .sd_addr(a_addr), .init_done(a_done));

  sdram_init_seq #(.CLK_MHZ(2), .WAIT_US(9), .T_RP(1), .T_RC(5), .T_MRD(3),
    .REFRESH_COUNT(1), .MRS_FIRST(1'b1), .MODE_WORD(11'h222)) u1 (
    .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_dqm(b_dqm), .sd_ba(b_ba),
    .sd_addr(b_addr), .init_done(b_done));

  // vector: {done, dqm, cke, cs_n, ras_n, cas_n, we_n, ba, addr[10:0]}
  function automatic logic [18:0] vec(input logic d, input logic [3:0] c, input logic [10:0] a);
    return {d, ~d, 1'b1, c, 1'b0, a};
  endfunction

  function automatic int clamp2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic logic [18:0] expect_at(input int k, input int wc, input int rp,
      input int rc, input int mrd, input int nref, input bit mf, input logic [10:0] mode);
    int t;
    int n;
    logic [18:0] nop;
    nop = vec(1'b0, 4'b0111, 11'h000);
    n = clamp2(nref);
    if (k < wc) return nop;                               // R1
    t = wc;
    if (k == t) return vec(1'b0, 4'b0010, 11'h400);       // R2
    t += clamp2(rp);                                      // R3
    if (mf) begin                                         // R6
      if (k < t) return nop;
      if (k == t) return vec(1'b0, 4'b0000, mode);        // R5
      t += clamp2(mrd);
    end
    for (int i = 0; i < n; i++) begin                     // R4
      if (k < t) return nop;
      if (k == t) return vec(1'b0, 4'b0001, 11'h000);
      t += clamp2(rc);
    end
    if (!mf) begin
      if (k < t) return nop;
      if (k == t) return vec(1'b0, 4'b0000, mode);
      t += clamp2(mrd);
    end
    if (k < t) return nop;
    return vec(1'b1, 4'b0111, 11'h000);                   // R7
  endfunction

  function automatic string tag_of(input logic [18:0] e, input int k, input int wc);
    if (k < wc) return "R1";
    if (e[18]) return "R7";
    if (e[14:11] == 4'b0010) return "R2";
    if (e[14:11] == 4'b0001) return "R4";
    if (e[14:11] == 4'b0000) return "R5/R6";
    return "R3";
  endfunction

  task automatic check_one(input string who, input logic [18:0] act, input logic [18:0] exp,
      input string tag, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, who, k, act, exp);
    end
  endtask

  task automatic sample(input int k, input string extra);
    logic [18:0] ea, eb;
    ea = expect_at(k, 25, 3, 4, 2, 3, 1'b0, 11'h037);
    eb = expect_at(k, 18, 1, 5, 3, 1, 1'b1, 11'h222);
    check_one("u0", {a_done, a_dqm, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr}, ea,
              {tag_of(ea, k, 25), extra}, k);
    check_one("u1", {b_done, b_dqm, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr}, eb,
              {tag_of(eb, k, 18), extra}, k);
  endtask

  // run: reset for 3 cycles (checked as R8/R9 state), then len samples after release
  task automatic run(input int len);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sample(0, " R8 R9");
    end
    rst_n = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      sample(k, "");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    run(60);           // full sequence, both orders, past completion
    run(1);            // reset right after release
    run(25);           // reset exactly at first precharge slot of u0
    run(43);           // reset just after u0 completes
    for (int r = 0; r < 6; r++) run(1 + int'($urandom % 55));
    run(70);           // final full run after random restarts
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule